// File: doc/BRIEF.md
# Card Command Error Checker

This block screens each parsed 48-bit command frame that reaches a memory card's command-path controller, before any state change happens. It recomputes the CRC-7 over the frame's leading 40 bits and compares the result with the received CRC field. It then looks up the command index in a combinational legality table. The table reports whether the index is defined, which command class it belongs to, and in which card states it is accepted. The class is checked against a supported-class mask supplied by the device configuration.

A command that passes every check produces a one-cycle execute strobe. It also produces a respond flag, unless the command is one that takes no response. A command that fails is silently suppressed: there is no strobe, no response and no state transition. The failure is reported only through two sticky status bits, which hold until the status-clear pulse that models the status being read.

Top module: `card_cmd_screen`

## Requirements
- R1: The expected CRC is CRC-7 with polynomial x^7+x^3+1 and a zero initial value. It is computed MSB first over 40 bits: a start bit of 0, a transmission bit of 1, the 6-bit index and the 32-bit argument. It is compared with `cmd_crc`.
- R2: A command with a CRC mismatch gives no `exec_stb` and no `respond`, and sets `err_crc` at the next clock edge.
- R3: An index that the table does not define is illegal; index 44 is undefined. The defined indices are 0, 1, 2, 3, 4, 7, 9, 10, 12, 13, 15, 16, 17, 18, 24, 25, 27, 35, 36, 38 and 42.
- R4: Each defined index has a class number, and the command is illegal when bit `class` of `class_mask` is 0. Index 17 is class 2, index 24 is class 4, and indices 0, 2 and 13 are class 0.
- R5: A command is illegal when it is not allowed in `card_state`. The state codes are idle=0, ready=1, ident=2, stby=3, tran=4, data=5, rcv=6, prg=7 and dis=8; codes 9 to 15 allow nothing. Index 2 is allowed only in ready. Indices 17 and 24 are allowed only in tran. Index 0 is allowed in every state from 0 to 8. Index 13 is allowed in states 3 to 8.
- R6: An illegal command with a good CRC gives no `exec_stb` and no `respond`, and sets `err_illegal` at the next clock edge.
- R7: When the CRC fails, only `err_crc` is set, even if the command would also be illegal.
- R8: Both error bits are sticky and clear only on `status_clr`. If a new error arrives in the same cycle as the clear, the bit stays set.
- R9: A command that passes every check raises `exec_stb` for exactly one cycle, at the clock edge that samples `cmd_valid`.
- R10: `respond` rises together with `exec_stb`, except for indices 0 and 4, which execute without a response.
- R11: After reset, all four outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | A parsed command is present this cycle |
| cmd_index | input | 6 | Command index |
| cmd_arg | input | 32 | Command argument |
| cmd_crc | input | 7 | Received CRC-7 field |
| card_state | input | 4 | Current card state code |
| class_mask | input | CLS_W | Supported-class mask, one bit per class |
| status_clr | input | 1 | Clears the sticky error bits |
| exec_stb | output | 1 | One-cycle execute strobe |
| respond | output | 1 | Request a response for the executed command |
| err_crc | output | 1 | Sticky communication-CRC error |
| err_illegal | output | 1 | Sticky illegal-command error |

## Verification
Every result has one register stage. The strobe, the respond flag and any newly set error bit appear at the clock edge that samples `cmd_valid`, and the strobe is gone by the following edge. The bench drives the inputs on the falling edge and samples 1 ns after the next rising edge. It checks the strobe's fall one edge later, and it checks stickiness after several idle edges. A clear takes effect at the edge that samples `status_clr`, so the bench samples the cleared state at that same point.

// File: rtl/card_cmd_screen.sv
module card_cmd_screen #(
  parameter int CLS_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  input  logic [5:0]       cmd_index,
  input  logic [31:0]      cmd_arg,
  input  logic [6:0]       cmd_crc,
  input  logic [3:0]       card_state,
  input  logic [CLS_W-1:0] class_mask,
  input  logic             status_clr,
  output logic             exec_stb,
  output logic             respond,
  output logic             err_crc,
  output logic             err_illegal
);
  localparam int CLS_BITS = (CLS_W > 1) ? $clog2(CLS_W) : 1;

  function automatic logic [6:0] crc7(input logic [39:0] d);
    logic [6:0] c;
    logic fb;
    c = '0;
    for (int i = 39; i >= 0; i--) begin
      fb = d[i] ^ c[6];
      c  = {c[5:0], 1'b0};
      if (fb) c = c ^ 7'h09;
    end
    return c;
  endfunction

  logic                crc_ok;
  logic                defined;
  logic [CLS_BITS-1:0] cls;
  logic [15:0]         st_ok;
  logic                no_resp;
  logic                illegal;
  logic                pass;

  assign crc_ok = (crc7({2'b01, cmd_index, cmd_arg}) == cmd_crc);

  always_comb begin
    defined = 1'b1;
    cls     = '0;
    st_ok   = '0;
    no_resp = 1'b0;
    case (cmd_index)
      6'd0:  begin st_ok = 16'h01FF; no_resp = 1'b1; end
      6'd1:  st_ok = 16'h0001;
      6'd2:  st_ok = 16'h0002;
      6'd3:  st_ok = 16'h0004;
      6'd4:  begin st_ok = 16'h0008; no_resp = 1'b1; end
      6'd7:  st_ok = 16'h01B8;
      6'd9, 6'd10: st_ok = 16'h0008;
      6'd12: st_ok = 16'h0060;
      6'd13, 6'd15: st_ok = 16'h01F8;
      6'd16, 6'd17, 6'd18: begin cls = CLS_BITS'(2); st_ok = 16'h0010; end
      6'd24, 6'd25, 6'd27: begin cls = CLS_BITS'(4); st_ok = 16'h0010; end
      6'd35, 6'd36, 6'd38: begin cls = CLS_BITS'(5); st_ok = 16'h0010; end
      6'd42: begin cls = CLS_BITS'(7); st_ok = 16'h0010; end
      default: defined = 1'b0;
    endcase
  end

  assign illegal = !defined || !class_mask[cls] || !st_ok[card_state];
  assign pass    = crc_ok && !illegal;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      exec_stb    <= 1'b0;
      respond     <= 1'b0;
      err_crc     <= 1'b0;
      err_illegal <= 1'b0;
    end else begin
      exec_stb    <= cmd_valid && pass;
      respond     <= cmd_valid && pass && !no_resp;
      err_crc     <= (err_crc && !status_clr) || (cmd_valid && !crc_ok);
      err_illegal <= (err_illegal && !status_clr) || (cmd_valid && crc_ok && illegal);
    end
  end
endmodule

// File: rtl/card_cmd_screen_chk.sv
module card_cmd_screen_chk (
  input logic clk,
  input logic rst_n,
  input logic cmd_valid,
  input logic status_clr,
  input logic exec_stb,
  input logic respond,
  input logic err_crc,
  input logic err_illegal
);
  AST_EXEC_NEEDS_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    exec_stb |-> $past(cmd_valid)); // R9
  AST_RESP_WITH_EXEC: assert property (@(posedge clk) disable iff (!rst_n)
    respond |-> exec_stb); // R10
  AST_CRC_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_crc) |-> !exec_stb && !respond); // R2
  AST_ILLEGAL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_illegal) |-> !exec_stb && !respond); // R6
  AST_CRC_PRIORITY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_crc) |-> !$rose(err_illegal)); // R7
  AST_CRC_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    $past(err_crc) && !$past(status_clr) |-> err_crc); // R8
  AST_ILL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    $past(err_illegal) && !$past(status_clr) |-> err_illegal); // R8
endmodule

bind card_cmd_screen card_cmd_screen_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .status_clr(status_clr),
  .exec_stb(exec_stb), .respond(respond), .err_crc(err_crc), .err_illegal(err_illegal)
);

// File: tb/card_cmd_screen_bench.sv
module card_cmd_screen_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic [5:0]  cmd_index = '0;
  logic [31:0] cmd_arg = '0;
  logic [6:0]  cmd_crc = '0;
  logic [3:0]  card_state = '0;
  logic [11:0] class_mask = '0;
  logic        status_clr = 1'b0;
  logic        exec_stb, respond, err_crc, err_illegal;
  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  card_cmd_screen u_card_cmd_screen (.*);

  function automatic logic [6:0] ref_crc(input logic [5:0] idx, input logic [31:0] arg);
    logic [46:0] r;
    r = {2'b01, idx, arg, 7'b0};
    for (int i = 46; i >= 7; i--)
      if (r[i]) r[i -: 8] = r[i -: 8] ^ 8'h89;
    return r[6:0];
  endfunction

  task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s outs{exec,resp,crc,ill} actual=%b expected=%b", req, act, exp);
    end
  endtask

  function automatic logic [3:0] outs();
    return {exec_stb, respond, err_crc, err_illegal};
  endfunction

  task automatic send(input logic [5:0] idx, input logic [31:0] arg, input logic [3:0] st,
                      input logic [11:0] mask, input bit bad, input bit clr);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_index = idx; cmd_arg = arg; card_state = st; class_mask = mask;
    cmd_crc = ref_crc(idx, arg) ^ (bad ? 7'h10 : 7'h00);
    status_clr = clr;
    @(posedge clk); #1;
    @(negedge clk);
    cmd_valid = 1'b0; status_clr = 1'b0;
  endtask

  task automatic clear_status();
    @(negedge clk); status_clr = 1'b1;
    @(posedge clk); #1;
    @(negedge clk); status_clr = 1'b0;
  endtask

  task automatic t_reset();
    #1 chk("R11", outs(), 4'b0000);
  endtask

  task automatic t_good_pulse();
    @(negedge clk);
    cmd_valid = 1'b1; cmd_index = 6'd17; cmd_arg = 32'h0000_0200; card_state = 4'd4;
    class_mask = 12'h004; cmd_crc = ref_crc(6'd17, 32'h0000_0200);
    @(posedge clk); #1 chk("R9 R1 R4 exec", outs(), 4'b1100);
    @(negedge clk); cmd_valid = 1'b0;
    @(posedge clk); #1 chk("R9 pulse width", outs(), 4'b0000);
  endtask

  task automatic t_bad_crc();
    @(negedge clk);
    cmd_valid = 1'b1; cmd_index = 6'd17; cmd_arg = 32'hDEAD_BEEF; card_state = 4'd4;
    class_mask = 12'h004; cmd_crc = ref_crc(6'd17, 32'hDEAD_BEEF) ^ 7'h01;
    @(posedge clk); #1 chk("R2 R1 crc reject", outs(), 4'b0010);
    @(negedge clk); cmd_valid = 1'b0;
    repeat (3) @(posedge clk);
    #1 chk("R8 crc sticky", outs(), 4'b0010);
    clear_status();
    chk("R8 crc clear", outs(), 4'b0000);
  endtask

  task automatic t_state();
    @(negedge clk);
    cmd_valid = 1'b1; cmd_index = 6'd2; cmd_arg = 32'h0; card_state = 4'd4;
    class_mask = 12'hFFF; cmd_crc = ref_crc(6'd2, 32'h0);
    @(posedge clk); #1 chk("R5 R6 idx2 in tran", outs(), 4'b0001);
    @(negedge clk); cmd_valid = 1'b0;
    clear_status();
    chk("R8 illegal clear", outs(), 4'b0000);
    @(negedge clk);
    cmd_valid = 1'b1; card_state = 4'd1;
    @(posedge clk); #1 chk("R5 idx2 in ready", outs(), 4'b1100);
    @(negedge clk); cmd_valid = 1'b0;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_index = 6'd13; cmd_arg = 32'h0001_0000; card_state = 4'd9;
    cmd_crc = ref_crc(6'd13, 32'h0001_0000);
    @(posedge clk); #1 chk("R5 state code 9", outs(), 4'b0001);
    @(negedge clk); cmd_valid = 1'b0;
    clear_status();
  endtask

  task automatic t_undefined();
    @(negedge clk);
    cmd_valid = 1'b1; cmd_index = 6'd44; cmd_arg = 32'h1234_5678; card_state = 4'd4;
    class_mask = 12'hFFF; cmd_crc = ref_crc(6'd44, 32'h1234_5678);
    @(posedge clk); #1 chk("R3 idx44", outs(), 4'b0001);
    @(negedge clk); cmd_valid = 1'b0;
    clear_status();
  endtask

  task automatic t_class();
    @(negedge clk);
    cmd_valid = 1'b1; cmd_index = 6'd24; cmd_arg = 32'h0000_0400; card_state = 4'd4;
    class_mask = 12'h0EF; cmd_crc = ref_crc(6'd24, 32'h0000_0400);
    @(posedge clk); #1 chk("R4 class4 unsupported", outs(), 4'b0001);
    @(negedge clk); cmd_valid = 1'b0;
    clear_status();
    @(negedge clk);
    cmd_valid = 1'b1; class_mask = 12'h010;
    @(posedge clk); #1 chk("R4 class4 supported", outs(), 4'b1100);
    @(negedge clk); cmd_valid = 1'b0;
  endtask

  task automatic t_no_resp();
    @(negedge clk);
    cmd_valid = 1'b1; cmd_index = 6'd0; cmd_arg = 32'h0; card_state = 4'd4;
    class_mask = 12'h001; cmd_crc = ref_crc(6'd0, 32'h0);
    @(posedge clk); #1 chk("R10 idx0 no response", outs(), 4'b1000);
    @(negedge clk); cmd_valid = 1'b0;
  endtask

  task automatic t_priority();
    send(6'd44, 32'hCAFE_0001, 4'd4, 12'hFFF, 1'b1, 1'b0);
    chk("R7 crc over illegal", outs(), 4'b0010);
    send(6'd2, 32'h0, 4'd4, 12'hFFF, 1'b1, 1'b1);
    chk("R8 set beats clear", outs(), 4'b0010);
    clear_status();
    chk("R8 cleared again", outs(), 4'b0000);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    t_reset();
    @(negedge clk); rst_n = 1'b1;
    t_good_pulse();
    t_bad_crc();
    t_state();
    t_undefined();
    t_class();
    t_no_resp();
    t_priority();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        checks++; failures++;
        $display("FAIL watchdog actual=hung expected=done");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule